// File: doc/BRIEF.md
# Bidirectional Integration Period Counter

This block is the digital timing core of a charge-balancing integrating converter. The analog integrator runs all the time and is steered by a reference-direction output. The integrator output feeds a hysteresis comparator. Each time the comparator trips, the block reverses the reference direction. The integrator then ramps back the other way, and the loop oscillates at a rate set by the input.

A measurement window opens at a comparator trip. While the window is open, the block counts clock cycles spent with the reference pointing positive (Tp) and pointing negative (Tm). The window closes at the first trip after at least `WIN_MIN` cycles have been counted, so both totals cover whole ramps. A serial restoring divider then forms the signed fraction (Tp−Tm)/(Tp+Tm) with 21 fractional bits. That fraction becomes a 22-bit offset-binary code after the stored zero offset is removed.

The zero offset comes from a zero measurement, taken with the analog inputs shorted together. One zero measurement runs by itself after reset, and more can be requested at any time. `WIN_MIN` sets the conversion time. At a 125 MHz clock, the nominal 320 ms conversion needs `WIN_MIN` = 40,000,000.

Top module: `chgbal_period_counter`

## Requirements
- R1: `comp_in` passes through a two-stage synchronizer. Every change of its level inverts `ref_dir` on the third rising clock edge after the change. `ref_dir` is 1 after reset, and 1 means the positive direction.
- R2: Reset holds `code` at 0x200000, `done` at 0, `busy` at 1 and `az_sel` at 1. After reset, a zero measurement starts with no request.
- R3: An accepted request does not start counting until the next comparator trip. While the window is open, each clock counts into Tp when `ref_dir` is 1 and into Tm when it is 0.
- R4: The window closes on the first trip seen when at least `WIN_MIN` cycles were counted before that cycle. The closing cycle itself is counted.
- R5: For a conversion, `code` = 0x200000 + s·floor(|Tp−Tm|·2^21/(Tp+Tm)) − offset. Here s is the sign of Tp−Tm. `code` is updated 22 cycles after the closing trip, in the same cycle as a one-cycle `done` pulse, and `code` is held at all other times.
- R6: A zero measurement keeps `az_sel` high while it runs. It stores its signed value s·floor(...) as the new offset, gives no `done` pulse and leaves `code` unchanged.
- R7: The corrected code clamps at 0x000000 and 0x3FFFFF rather than wrapping.
- R8: `start` and `zero_req` are ignored while `busy` is 1. When both arrive together while idle, `start` wins and a conversion runs.
- R9: `busy` rises on the edge after an accepted request and falls in the cycle that ends the division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| comp_in | input | 1 | Asynchronous comparator output from the integrator |
| start | input | 1 | Conversion request, sampled when idle |
| zero_req | input | 1 | Zero-measurement request, sampled when idle |
| ref_dir | output | 1 | Reference current direction, 1 = positive |
| az_sel | output | 1 | Shorts the analog inputs during a zero measurement |
| busy | output | 1 | Measurement or division in progress |
| done | output | 1 | One-cycle pulse when a new conversion code is valid |
| code | output | 22 | Corrected offset-binary result |

## Verification
The assertions check the timing shape of the handshake on every cycle:
- `done` is a single-cycle pulse and is raised only as `busy` drops.
- `code` never moves without `done`.
- A zero measurement never pulses `done`.
- Idle requests are accepted in the right mode.
- No result arrives before the minimum window has run.

The numeric result needs the bench's scenarios, which run a behavioural model of trips, counts and division alongside the design. These scenarios cover the value of the ratio, offset subtraction, clamping at both ends, window alignment to trips, and the exact cycle on which `ref_dir` flips.

// File: rtl/chgbal_period_counter.sv
module chgbal_period_counter #(
  parameter int CNT_W   = 32,
  parameter int WIN_MIN = 40_000_000,
  parameter int RES_W   = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             comp_in,
  input  logic             start,
  input  logic             zero_req,
  output logic             ref_dir,
  output logic             az_sel,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] code
);

  localparam int SW = CNT_W + 1;
  localparam int RW = CNT_W + 2;
  localparam int VW = RES_W + 3;
  localparam int IW = $clog2(RES_W);
  localparam logic [VW-1:0] MID = VW'(1) << (RES_W - 1);
  localparam logic [VW-1:0] TOP = (VW'(1) << RES_W) - VW'(1);
  localparam logic [CNT_W-1:0] WIN_L = CNT_W'(WIN_MIN);

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_MEAS, S_DIV} st_t;

  st_t                     st;
  logic                    c1, c2, c3;
  logic                    az_m;
  logic                    neg;
  logic [CNT_W-1:0]        tp, tm, win;
  logic [SW-1:0]           sum;
  logic [RW-1:0]           rem;
  logic [RES_W-2:0]        quo;
  logic [IW-1:0]           idx;
  logic signed [VW-1:0]    off;

  logic                    trip, close, tp_ge, ge, last;
  logic [CNT_W-1:0]        tp_n, tm_n, mag_n;
  logic [SW-1:0]           sum_n;
  logic [RW-1:0]           rem_sub;
  logic [RES_W-1:0]        q, sat;
  logic signed [VW-1:0]    qv, val, fix;

  assign trip    = c2 ^ c3;
  assign tp_n    = tp + {{(CNT_W-1){1'b0}}, ref_dir};
  assign tm_n    = tm + {{(CNT_W-1){1'b0}}, ~ref_dir};
  assign close   = trip && (win >= WIN_L);
  assign tp_ge   = tp_n >= tm_n;
  assign sum_n   = {1'b0, tp_n} + {1'b0, tm_n};
  assign mag_n   = tp_ge ? tp_n - tm_n : tm_n - tp_n;

  assign ge      = rem >= {1'b0, sum};
  assign rem_sub = ge ? rem - {1'b0, sum} : rem;
  assign q       = {quo, ge};
  assign last    = idx == IW'(RES_W - 1);
  assign qv      = $signed({{(VW-RES_W){1'b0}}, q});
  assign val     = neg ? -qv : qv;
  assign fix     = $signed(MID) + val - off;
  assign sat     = (fix < 0) ? '0 : ((fix > $signed(TOP)) ? TOP[RES_W-1:0] : fix[RES_W-1:0]);

  assign busy    = st != S_IDLE;
  assign az_sel  = az_m && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= 1'b0; c2 <= 1'b0; c3 <= 1'b0;
      ref_dir <= 1'b1;
      st   <= S_ARM;
      az_m <= 1'b1;
      tp <= '0; tm <= '0; win <= '0;
      sum <= '0; rem <= '0; quo <= '0; idx <= '0;
      neg  <= 1'b0;
      off  <= '0;
      done <= 1'b0;
      code <= MID[RES_W-1:0];
    end else begin
      c1 <= comp_in;
      c2 <= c1;
      c3 <= c2;
      ref_dir <= ref_dir ^ trip;
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st <= S_ARM; az_m <= 1'b0;
          end else if (zero_req) begin
            st <= S_ARM; az_m <= 1'b1;
          end
        end
        S_ARM: begin
          if (trip) begin
            st <= S_MEAS;
            tp <= '0; tm <= '0; win <= '0;
          end
        end
        S_MEAS: begin
          tp <= tp_n;
          tm <= tm_n;
          if (win < WIN_L) win <= win + CNT_W'(1);
          if (close) begin
            st  <= S_DIV;
            sum <= sum_n;
            rem <= {2'b00, mag_n};
            neg <= ~tp_ge;
            quo <= '0;
            idx <= '0;
          end
        end
        S_DIV: begin
          rem <= rem_sub << 1;
          quo <= q[RES_W-2:0];
          idx <= idx + IW'(1);
          if (last) begin
            st <= S_IDLE;
            if (az_m) off <= val;
            else begin
              code <= sat;
              done <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chgbal_checks.sv
module chgbal_checks #(
  parameter int WIN_MIN = 1,
  parameter int RES_W   = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             zero_req,
  input logic             busy,
  input logic             done,
  input logic             az_sel,
  input logic [RES_W-1:0] code
);

  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (busy) run <= run + 32'd1;
    else run <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(code)); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9

  AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    az_sel |-> !done); // R6

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !az_sel)); // R8

  AST_ZERO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && zero_req && !start) |=> az_sel); // R8

  AST_MIN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run >= 32'(WIN_MIN + 20))); // R4

endmodule

bind chgbal_period_counter chgbal_checks #(.WIN_MIN(WIN_MIN), .RES_W(RES_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .zero_req(zero_req),
  .busy(busy), .done(done), .az_sel(az_sel), .code(code)
);

// File: tb/tb_chgbal_period_counter.sv
module tb_chgbal_period_counter;

  localparam int CW  = 16;
  localparam int WM  = 64;
  localparam int RW  = 22;
  localparam longint MIDV = 64'd1 << (RW - 1);
  localparam longint TOPV = (64'd1 << RW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic comp_in = 1'b0;
  logic start = 1'b0;
  logic zero_req = 1'b0;
  logic ref_dir, az_sel, busy, done;
  logic [RW-1:0] code;

  int n_chk = 0;
  int n_fail = 0;
  int lo_len = 10;
  int hi_len = 10;
  bit finished = 0;

  chgbal_period_counter #(.CNT_W(CW), .WIN_MIN(WM), .RES_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .comp_in(comp_in), .start(start), .zero_req(zero_req),
    .ref_dir(ref_dir), .az_sel(az_sel), .busy(busy), .done(done), .code(code)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // comparator stimulus: low for lo_len cycles, high for hi_len cycles
  initial begin
    forever begin
      repeat (lo_len) @(negedge clk);
      comp_in = 1'b1;
      repeat (hi_len) @(negedge clk);
      comp_in = 1'b0;
    end
  end

  // behavioural reference model
  int h1, h2, h3;
  bit m_dir, m_az, m_done, m_live, e, d;
  int m_st, wait_n;
  longint tp, tm, win, m_val, m_off, m_code;

  function automatic longint ratio(input longint p, input longint m);
    longint s, mag, qq;
    s = p + m;
    mag = (p >= m) ? p - m : m - p;
    qq = (mag << (RW - 1)) / s;
    return (p >= m) ? qq : -qq;
  endfunction

  function automatic longint clampv(input longint x);
    if (x < 0) return 0;
    if (x > TOPV) return TOPV;
    return x;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0;
      m_dir = 1; m_st = 1; m_az = 1;
      tp = 0; tm = 0; win = 0; wait_n = 0;
      m_off = 0; m_code = MIDV; m_done = 0; m_live = 1;
    end else begin
      e = (h2 != h3);
      d = m_dir;
      m_done = 0;
      case (m_st)
        0: if (start) begin m_st = 1; m_az = 0; end
           else if (zero_req) begin m_st = 1; m_az = 1; end
        1: if (e) begin m_st = 2; tp = 0; tm = 0; win = 0; end
        2: begin
          if (d) tp++; else tm++;
          if (e && win >= WM) begin
            m_st = 3; wait_n = RW; m_val = ratio(tp, tm);
          end
          win++;
        end
        default: begin
          wait_n--;
          if (wait_n == 0) begin
            m_st = 0;
            if (m_az) m_off = m_val;
            else begin m_code = clampv(MIDV + m_val - m_off); m_done = 1; end
          end
        end
      endcase
      m_dir = d ^ e;
      h3 = h2; h2 = h1; h1 = int'(comp_in);
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_live) begin
      chk("R1 ref_dir", longint'(ref_dir), longint'(m_dir));
      chk("R9 busy", longint'(busy), longint'(m_st != 0));
      chk("R6 az_sel", longint'(az_sel), longint'(m_az && m_st != 0));
      chk("R5 done", longint'(done), longint'(m_done));
      chk("R5 code", longint'(code), m_code);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic pulse(input bit s, input bit z);
    @(negedge clk);
    start = s; zero_req = z;
    @(negedge clk);
    start = 0; zero_req = 0;
  endtask

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk("R2 reset code", longint'(code), MIDV);
    chk("R2 reset done", longint'(done), 0);
    chk("R2 reset ref_dir", longint'(ref_dir), 1);
    chk("R2 reset busy", longint'(busy), 1);
    chk("R2 reset az_sel", longint'(az_sel), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 zero run after reset", longint'(az_sel), 1);
    wait_idle();
    chk("R6 zero leaves code", longint'(code), MIDV);

    // conversion with start repeated while busy
    pulse(1, 0);
    chk("R9 busy after start", longint'(busy), 1);
    n = 1;
    repeat (5) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    zero_req = 1; @(negedge clk); zero_req = 0;
    n += 7;
    while (!done) begin @(negedge clk); n++; end
    chk("R4 window length", longint'(n >= WM + 22), 1);
    @(negedge clk);
    chk("R8 no restart from busy start", longint'(busy), 0);

    // asymmetric ramps
    lo_len = 7; hi_len = 19;
    pulse(1, 0);
    wait_idle();
    lo_len = 23; hi_len = 5;
    pulse(1, 0);
    wait_idle();

    // start wins over zero_req
    lo_len = 9; hi_len = 13;
    pulse(1, 1);
    chk("R8 start priority az_sel", longint'(az_sel), 0);
    chk("R8 start priority busy", longint'(busy), 1);
    wait_idle();

    // R3: frozen comparator keeps the measurement from starting
    lo_len = 600; hi_len = 600;
    @(negedge clk);
    while (comp_in == 1'b0) @(negedge clk);
    repeat (4) @(negedge clk);
    pulse(1, 0);
    repeat (WM + 60) @(negedge clk);
    chk("R3 waits for trip busy", longint'(busy), 1);
    chk("R3 waits for trip done", longint'(done), 0);
    lo_len = 11; hi_len = 11;
    wait_idle();

    // clamp low
    lo_len = 60; hi_len = 2;
    pulse(0, 1);
    chk("R6 zero request az_sel", longint'(az_sel), 1);
    wait_idle();
    lo_len = 2; hi_len = 60;
    pulse(1, 0);
    wait_idle();
    chk("R7 clamp low", longint'(code), 0);

    // clamp high
    pulse(0, 1);
    wait_idle();
    lo_len = 60; hi_len = 2;
    pulse(1, 0);
    wait_idle();
    chk("R7 clamp high", longint'(code), TOPV);

    // balanced zero then balanced conversion
    lo_len = 10; hi_len = 10;
    pulse(0, 1);
    wait_idle();
    pulse(1, 0);
    wait_idle();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule